// File: doc/BRIEF.md
# I2C Transmit/Receive Byte FIFOs with Trigger Flags

This block holds the two byte queues that sit between a register interface and an I2C bus engine. Software pushes outgoing bytes through a data port and pops incoming bytes through the same port. The bus engine takes transmit bytes from a ready/take stream and pushes received bytes into the receive queue. Each queue is 16 bytes deep by default. Software can empty each queue on its own through a control write.

Three sticky status flags describe the queue state. The receive flag means the programmed receive threshold is reached. The transmit flag means the transmit queue has drained to its selected low-water mark. The end flag means the engine finished a byte while the transmit queue was empty. Each flag is cleared by writing zero to its bit. A per-flag enable mask forms a single interrupt line. Two read-only registers report the occupancy of each queue.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset, both occupancy counts are 0, every register reads 0, `tx_valid` is 0 and `irq` is 0.
- R2: Bytes written to the data port (address 3) leave on `tx_data` in write order. `tx_valid` is high while the transmit queue holds a byte. A `tx_take` pulse removes the head byte.
- R3: A data-port write while the transmit queue holds 16 bytes is dropped, and the transmit count stays at 16.
- R4: A data-port read returns the oldest received byte and removes it at that clock edge. A read of an empty receive queue returns 0 and changes nothing.
- R5: An `rx_push` while the receive queue holds 16 bytes is dropped.
- R6: A write to control (address 0) with bit 1 set empties the receive queue. Bit 0 set empties the transmit queue and drops any data write in the same cycle. Both bits read back as 0. Bits 7:4 and 3:2 read back as written.
- R7: Status bit 1 (receive trigger) is set one cycle after the receive count reaches control bits 7:4 plus one.
- R8: Status bit 0 (transmit trigger) is set one cycle after the transmit count is at or below the mark chosen by control bits 3:2: code 0 gives 8, code 1 gives 4, code 2 gives 2, code 3 gives 0.
- R9: Status bit 2 (transmit end) is set one cycle after a `tx_sent` pulse that arrives while the transmit queue is empty. An accepted data write or a transmit reset ends that condition.
- R10: Writing status (address 1) clears each flag whose written bit is 0. A bit written as 1 leaves its flag alone. A cleared flag whose condition still holds sets again on the next cycle.
- R11: `irq` is high whenever some status bit and the same bit of the enable register (address 2, bits 2:0) are both 1.
- R12: Address 4 reads the receive count and address 5 reads the transmit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at data port) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on address |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_data | output | 8 | Head of transmit queue |
| tx_take | input | 1 | Engine removes head transmit byte |
| tx_sent | input | 1 | Engine finished shifting a byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Masked OR of status flags |

## Verification
Queue contents and counts change at the clock edge that samples the strobe. They appear on `reg_rdata` and `tx_data` in the same cycle after that edge. Status flags sample the condition as it stands after that edge, so they lag by one more cycle, and `irq` follows them with no extra delay. A behavioural reference built from queues is advanced on the same edge as the design. Inputs change shortly after the rising edge, and every output is compared to the reference at the falling edge. Directed checks leave an idle cycle before each flag read, except where the zero-write clear is observed in the very next cycle.

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_take,
  input  logic          tx_sent,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2,
                         A_DATA = 3'd3, A_RXC  = 3'd4, A_TXC = 3'd5;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] txm [DEPTH];
  logic [DW-1:0] rxm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_mark;
  logic [3:0]    rx_trig;
  logic [1:0]    tx_code;
  logic [2:0]    flags, ien, cond;
  logic          drained;

  wire ctrl_wr = reg_wr && reg_addr == A_CTRL;
  wire stat_wr = reg_wr && reg_addr == A_STAT;
  wire tx_rst  = ctrl_wr && reg_wdata[0];
  wire rx_rst  = ctrl_wr && reg_wdata[1];
  wire tx_in   = reg_wr && reg_addr == A_DATA && tx_cnt != FULL && !tx_rst;
  wire tx_out  = tx_take && tx_cnt != '0 && !tx_rst;
  wire rx_in   = rx_push && rx_cnt != FULL && !rx_rst;
  wire rx_out  = reg_rd && reg_addr == A_DATA && rx_cnt != '0 && !rx_rst;

  always_comb begin
    case (tx_code)
      2'd0:    tx_mark = CW'(8);
      2'd1:    tx_mark = CW'(4);
      2'd2:    tx_mark = CW'(2);
      default: tx_mark = '0;
    endcase
  end

  assign cond[0] = tx_cnt <= tx_mark;
  assign cond[1] = rx_cnt >= CW'(rx_trig) + CW'(1);
  assign cond[2] = drained;

  always_ff @(posedge clk) begin
    if (tx_in) txm[tx_wp] <= reg_wdata[DW-1:0];
    if (rx_in) rxm[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rx_trig <= '0; tx_code <= '0; ien <= '0; flags <= '0; drained <= 1'b0;
    end else begin
      if (tx_rst) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      end else begin
        if (tx_in)  tx_wp <= tx_wp + 1'b1;
        if (tx_out) tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
      end
      if (rx_rst) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (rx_in)  rx_wp <= rx_wp + 1'b1;
        if (rx_out) rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
      end
      if (ctrl_wr) begin
        rx_trig <= reg_wdata[7:4];
        tx_code <= reg_wdata[3:2];
      end
      if (reg_wr && reg_addr == A_IEN) ien <= reg_wdata[2:0];
      if (tx_in || tx_rst)                drained <= 1'b0;
      else if (tx_sent && tx_cnt == '0)   drained <= 1'b1;
      flags <= stat_wr ? ((flags | cond) & reg_wdata[2:0]) : (flags | cond);
    end
  end

  assign tx_valid = tx_cnt != '0;
  assign tx_data  = txm[tx_rp];
  assign irq      = |(flags & ien);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {rx_trig, tx_code, 2'b00};
      A_STAT:  reg_rdata = {5'b0, flags};
      A_IEN:   reg_rdata = {5'b0, ien};
      A_DATA:  reg_rdata = (rx_cnt != '0) ? 8'(rxm[rx_rp]) : 8'h00;
      A_RXC:   reg_rdata = 8'(rx_cnt);
      A_TXC:   reg_rdata = 8'(tx_cnt);
      default: reg_rdata = 8'h00;
    endcase
  end

  p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt == FULL && reg_wr && reg_addr == A_DATA && !tx_take |=> tx_cnt == FULL);
  p_rx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt == FULL && rx_push && !reg_rd && !ctrl_wr |=> rx_cnt == FULL);
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == A_DATA && rx_cnt == '0 |-> reg_rdata == 8'h00);
  p_rx_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> rx_cnt == '0);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && !reg_wdata[1] |=> !flags[1]);
  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sent && !tx_valid && !reg_wr |=> ##1 flags[2]);
endmodule

// File: tb/i2c_fifo_pair_tb.sv
module i2c_fifo_pair_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, tx_take = 0, tx_sent = 0, rx_push = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, rx_data = 0;
  logic [7:0] reg_rdata, tx_data;
  logic tx_valid, irq;
  int errors = 0, checks = 0;
  bit run = 0;

  always #10 clk = ~clk;

  i2c_fifo_pair u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take), .tx_sent(tx_sent),
    .rx_push(rx_push), .rx_data(rx_data), .irq(irq));

  byte unsigned txq[$], rxq[$];
  int m_rxtrig = 0, m_code = 0, m_ien = 0, m_flags = 0;
  bit m_drain = 0;

  function automatic int mark(int c);
    return c == 0 ? 8 : c == 1 ? 4 : c == 2 ? 2 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_rxtrig = 0; m_code = 0; m_ien = 0; m_flags = 0; m_drain = 0;
    end else begin
      automatic int c = 0;
      automatic int ts = txq.size(), rs = rxq.size();
      automatic bit trst = reg_wr && reg_addr == 0 && reg_wdata[0];
      automatic bit rrst = reg_wr && reg_addr == 0 && reg_wdata[1];
      automatic bit tin = reg_wr && reg_addr == 3 && ts < 16 && !trst;
      if (ts <= mark(m_code)) c |= 1;
      if (rs >= m_rxtrig + 1) c |= 2;
      if (m_drain) c |= 4;
      if (reg_wr && reg_addr == 1) m_flags = (m_flags | c) & reg_wdata[2:0];
      else m_flags = m_flags | c;
      if (tin || trst) m_drain = 0;
      else if (tx_sent && ts == 0) m_drain = 1;
      if (trst) txq.delete();
      else begin
        if (tx_take && ts > 0) void'(txq.pop_front());
        if (tin) txq.push_back(reg_wdata);
      end
      if (rrst) rxq.delete();
      else begin
        if (reg_rd && reg_addr == 3 && rs > 0) void'(rxq.pop_front());
        if (rx_push && rs < 16) rxq.push_back(rx_data);
      end
      if (reg_wr && reg_addr == 0) begin m_rxtrig = reg_wdata[7:4]; m_code = reg_wdata[3:2]; end
      if (reg_wr && reg_addr == 2) m_ien = reg_wdata[2:0];
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (run) begin
    automatic int e;
    case (reg_addr)
      0: e = (m_rxtrig << 4) | (m_code << 2);
      1: e = m_flags;
      2: e = m_ien;
      3: e = rxq.size() ? rxq[0] : 0;
      4: e = rxq.size();
      5: e = txq.size();
      default: e = 0;
    endcase
    chk(reg_addr == 1 ? "R10 status" : reg_addr == 3 ? "R4 data" : "R12 regs", reg_rdata, e);
    chk("R11 irq", irq, (m_flags & m_ien) != 0);
    chk("R2 tx_valid", tx_valid, txq.size() != 0);
    if (txq.size()) chk("R2 tx_data", tx_data, txq[0]);
  end

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(posedge clk); #2 reg_wr = 0;
  endtask
  task automatic rdchk(int a, int exp, string tag);
    reg_addr = 3'(a);
    @(negedge clk); chk(tag, reg_rdata, exp);
    @(posedge clk); #2;
  endtask
  task automatic pop_rx(int exp, string tag);
    reg_rd = 1; reg_addr = 3;
    @(negedge clk); chk(tag, reg_rdata, exp);
    @(posedge clk); #2 reg_rd = 0;
  endtask
  task automatic take(int exp, string tag);
    @(negedge clk); chk(tag, tx_data, exp);
    #8 tx_take = 1; @(posedge clk); #2 tx_take = 0;
  endtask
  task automatic push_rx(int d);
    rx_push = 1; rx_data = 8'(d); @(posedge clk); #2 rx_push = 0;
  endtask
  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; run = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) if (a != 1) rdchk(a, 0, "R1 reset reg");
    chk("R1 irq", irq, 0); chk("R1 tx_valid", tx_valid, 0);
    // R2 order, R12 count
    wr(3, 'hA1); wr(3, 'hA2); wr(3, 'hA3);
    rdchk(5, 3, "R12 txcount");
    take('hA1, "R2 head");
    // R3 overflow
    for (int i = 0; i < 20; i++) wr(3, 'h10 + i);
    rdchk(5, 16, "R3 full count");
    take('hA2, "R2 order"); take('hA3, "R2 order");
    for (int i = 0; i < 14; i++) take('h10 + i, "R3 R2 kept bytes");
    rdchk(5, 0, "R12 drained");
    // R9 end flag
    tx_sent = 1; @(posedge clk); #2 tx_sent = 0;
    idle(1);
    rdchk(1, 5, "R9 end and R8 trigger");
    wr(1, 0); rdchk(1, 0, "R10 cleared");
    rdchk(1, 5, "R10 reasserts");
    wr(1, 7); rdchk(1, 5, "R10 one has no effect");
    wr(3, 'h55); wr(1, 0); idle(1);
    rdchk(1, 1, "R9 end ends on push");
    // R8 trigger codes
    wr(0, 'h01); for (int i = 0; i < 5; i++) wr(3, i);
    wr(0, 'h08); wr(1, 0); idle(1);
    rdchk(1, 0, "R8 code2 above mark");
    wr(0, 'h04); wr(1, 0); idle(1);
    rdchk(1, 0, "R8 code1 above mark");
    wr(0, 'h00); idle(1);
    rdchk(1, 1, "R8 code0 at or below 8");
    wr(0, 'h0C); wr(1, 0); idle(1);
    rdchk(1, 0, "R8 code3 nonempty");
    wr(0, 'h08);
    take(0, "R2"); take(1, "R2"); take(2, "R2");
    wr(1, 0); idle(1);
    rdchk(1, 1, "R8 code2 at 2");
    // R7 rx trigger, R4 read
    wr(0, 'h38);
    push_rx('hB0); push_rx('hB1); push_rx('hB2);
    wr(1, 0); idle(1);
    rdchk(1, 1, "R7 below trigger");
    push_rx('hB3); idle(1);
    rdchk(1, 3, "R7 trigger reached");
    rdchk(4, 4, "R12 rxcount");
    pop_rx('hB0, "R4"); pop_rx('hB1, "R4"); pop_rx('hB2, "R4"); pop_rx('hB3, "R4");
    pop_rx(0, "R4 empty read");
    rdchk(4, 0, "R4 empty unchanged");
    // R5 rx overflow
    for (int i = 0; i < 18; i++) push_rx('h40 + i);
    rdchk(4, 16, "R5 full");
    pop_rx('h40, "R5 first kept");
    // R11 irq
    wr(2, 0); idle(1); chk("R11 masked", irq, 0);
    wr(2, 2); idle(1); chk("R11 rx enabled", irq, 1);
    rdchk(2, 2, "R11 enable readback");
    // R6 resets
    wr(0, 'h02); rdchk(4, 0, "R6 rx reset");
    rdchk(5, 2, "R6 tx untouched");
    rdchk(0, 0, "R6 readback");
    wr(0, 'hF5); rdchk(5, 0, "R6 tx reset");
    rdchk(0, 'hF4, "R6 fields");
    idle(3);
    run = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule